// File: doc/BRIEF.md
# Priority Interrupt Presenter

This block sits between a source controller and one processor. It keeps a single pending interrupt for that processor and drives the processor's interrupt line while one is pending. The source controller offers delivery requests, each a source number and a priority. The presenter takes a request or refuses it. When a more favoured request arrives, it evicts the source it was holding and bounces that source back so that it can be offered again later. A numerically lower priority is more favoured, and the value 0xFF stands for "least favoured / none".

The processor talks to the presenter through a register port. It can take the pending interrupt (a read with side effects), peek at the state, set its current priority, set the priority of the inter-processor interrupt, and signal end-of-interrupt. The inter-processor interrupt is a pseudo-source with a reserved number. It is raised from a priority register, not by the source controller, and it is never bounced. Some priority changes evict the pending source. Others ask the source controller, through a one-cycle pulse, to re-offer sources it has held back. End-of-interrupt forwards the finished source number to the source controller.

Top module: `irq_presenter`

## Requirements
- R1: After reset the status word is 0x00000000 (current priority 0x00, nothing pending), the IPI priority and the pending priority are 0xFF, and `int_out` is low.
- R2: A delivery request whose priority is greater than or equal to the current priority gets a `dlv_refused` pulse in the next cycle, and the state does not change.
- R3: A delivery request is also refused when a source is pending and the pending priority is less than or equal to the request's priority.
- R4: Every delivery request gets exactly one answer, either `dlv_taken` or `dlv_refused`, in the cycle after it is presented. A taken request latches its source number and priority and raises `int_out`. If a real source (not the IPI) was pending, that source is reported on `bounce_valid`/`bounce_src` in the same cycle.
- R5: Op 4 (set IPI priority, value in `reg_wdata[7:0]`) stores the value. If the value is below the current priority, and no source is pending with a pending priority at or below the value, then the pending number becomes 2 and the pending priority becomes the value. Any real source that was pending is bounced. In every other case only the stored value changes.
- R6: Op 1 (accept) returns the old status word on `rd_word` and the IPI priority on `rd_ipi`, with `rd_valid` set. It then loads the current priority with the old pending priority, clears the pending number, sets the pending priority to 0xFF and lowers `int_out`.
- R7: Op 3 (set current priority, value in `reg_wdata[7:0]`) with a value below the old one drops a pending source whose pending priority is at or above the new value. The line is lowered, and a real source is bounced.
- R8: Op 3 with a value at or above the old one, while nothing is pending, pulses `resend_req`. If the IPI priority is then below the new current priority, the IPI becomes pending as in R5.
- R9: Op 5 (end-of-interrupt) copies `reg_wdata[31:24]` into the current priority and pulses `eoi_valid` with `eoi_src = reg_wdata[23:0]`. If nothing is pending, it also performs the resend of R8 against the new current priority.
- R10: Op 2 (poll) returns the status word and the IPI priority and changes no state.
- R11: The IPI pseudo-source (number 2) is never reported on the bounce lane, even when it is evicted or dropped. At most one bounce is reported per cycle.
- R12: When a register operation and a delivery request come in the same cycle, the operation is applied first and the request is judged against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Delivery request strobe |
| dlv_src | input | 24 | Source number of the request (nonzero, never 2) |
| dlv_prio | input | 8 | Priority of the request |
| dlv_taken | output | 1 | Request of the previous cycle was taken |
| dlv_refused | output | 1 | Request of the previous cycle was refused |
| bounce_valid | output | 1 | An evicted source is being handed back |
| bounce_src | output | 24 | Number of the evicted source |
| reg_valid | input | 1 | Register operation strobe |
| reg_op | input | 3 | Operation: 1 accept, 2 poll, 3 set current priority, 4 set IPI priority, 5 end-of-interrupt |
| reg_wdata | input | 32 | Operand of the operation |
| rd_valid | output | 1 | Read data of an accept or poll is valid |
| rd_word | output | 32 | Status word: priority in 31:24, pending number in 23:0 |
| rd_ipi | output | 8 | IPI priority register |
| eoi_valid | output | 1 | End-of-interrupt notification to the source controller |
| eoi_src | output | 24 | Source number being ended |
| resend_req | output | 1 | Request for sources to re-offer held-back interrupts |
| int_out | output | 1 | Interrupt line to the processor |

## Verification
Several properties are checked on every cycle: each request gets exactly one answer, low-priority requests and requests that lose to a pending source are refused, a taken request raises the line, accept lowers it, poll leaves all state unchanged, end-of-interrupt forwards its operand, and the IPI number never shows on the bounce lane. Other behaviour can only be shown by the bench's scenarios. This covers the exact status word after sequences such as evicting to the IPI, dropping on a priority drop, and the resend that re-raises the IPI after end-of-interrupt. It also covers the ordering rule when an operation and a request arrive together.

// File: rtl/irqp_pkg.sv
`timescale 1ns/1ps
package irqp_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ACCEPT  = 3'd1,
    OP_POLL    = 3'd2,
    OP_SET_CUR = 3'd3,
    OP_SET_IPI = 3'd4,
    OP_EOI     = 3'd5
  } op_e;

endpackage

// File: rtl/irqp_ipi_check.sv
`timescale 1ns/1ps
// Decides whether the inter-processor pseudo-source displaces the pending one.
module irqp_ipi_check #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic              en,
  input  logic [PRIO_W-1:0] cur,
  input  logic [PRIO_W-1:0] ipi,
  input  logic [SRC_W-1:0]  psrc,
  input  logic [PRIO_W-1:0] pprio,
  input  logic              isipi,
  output logic              hit,
  output logic [SRC_W-1:0]  o_psrc,
  output logic [PRIO_W-1:0] o_pprio,
  output logic              bnc_v
);

  logic has_pend;
  logic pend_holds;

  assign has_pend   = (psrc != '0);
  assign pend_holds = has_pend && (pprio <= ipi);
  assign hit        = en && (ipi < cur) && !pend_holds;
  assign o_psrc     = SRC_W'(IPI_SRC);
  assign o_pprio    = ipi;
  assign bnc_v      = hit && has_pend && !isipi;

endmodule

// File: rtl/irqp_regop.sv
`timescale 1ns/1ps
// Next-state logic of the processor-side register operations.
module irqp_regop import irqp_pkg::*; #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    op_v,
  input  op_e                     op,
  input  logic [SRC_W+PRIO_W-1:0] wdata,
  input  logic [PRIO_W-1:0]       cur,
  input  logic [SRC_W-1:0]        psrc,
  input  logic [PRIO_W-1:0]       pprio,
  input  logic                    isipi,
  input  logic [PRIO_W-1:0]       ipi,
  output logic [PRIO_W-1:0]       n_cur,
  output logic [SRC_W-1:0]        n_psrc,
  output logic [PRIO_W-1:0]       n_pprio,
  output logic                    n_isipi,
  output logic [PRIO_W-1:0]       n_ipi,
  output logic                    bnc_v,
  output logic                    resend,
  output logic                    eoi_v,
  output logic                    rd_v
);

  localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

  logic [PRIO_W-1:0] setv;
  logic [PRIO_W-1:0] eoi_prio;
  logic              has_pend;

  logic [PRIO_W-1:0] a_cur, a_pprio, a_ipi;
  logic [SRC_W-1:0]  a_psrc;
  logic              a_isipi, a_bnc;
  logic              chk_req;
  logic [PRIO_W-1:0] chk_cur, chk_ipi;

  logic              c_hit, c_bnc;
  logic [SRC_W-1:0]  c_psrc;
  logic [PRIO_W-1:0] c_pprio;

  assign setv     = wdata[PRIO_W-1:0];
  assign eoi_prio = wdata[SRC_W +: PRIO_W];
  assign has_pend = (psrc != '0);

  always_comb begin
    a_cur   = cur;
    a_psrc  = psrc;
    a_pprio = pprio;
    a_isipi = isipi;
    a_ipi   = ipi;
    a_bnc   = 1'b0;
    resend  = 1'b0;
    eoi_v   = 1'b0;
    rd_v    = 1'b0;
    chk_req = 1'b0;
    chk_cur = cur;
    chk_ipi = ipi;
    if (op_v) begin
      case (op)
        OP_ACCEPT: begin
          rd_v    = 1'b1;
          a_cur   = pprio;
          a_psrc  = '0;
          a_pprio = PRIO_NONE;
          a_isipi = 1'b0;
        end
        OP_POLL: begin
          rd_v = 1'b1;
        end
        OP_SET_CUR: begin
          a_cur = setv;
          if (setv < cur) begin
            if (has_pend && (setv <= pprio)) begin
              a_psrc  = '0;
              a_pprio = PRIO_NONE;
              a_isipi = 1'b0;
              a_bnc   = !isipi;
            end
          end else if (!has_pend) begin
            resend  = 1'b1;
            chk_req = 1'b1;
            chk_cur = setv;
          end
        end
        OP_SET_IPI: begin
          a_ipi   = setv;
          chk_req = 1'b1;
          chk_ipi = setv;
        end
        OP_EOI: begin
          a_cur = eoi_prio;
          eoi_v = 1'b1;
          if (!has_pend) begin
            resend  = 1'b1;
            chk_req = 1'b1;
            chk_cur = eoi_prio;
          end
        end
        default: begin
        end
      endcase
    end
  end

  irqp_ipi_check #(
    .SRC_W  (SRC_W),
    .PRIO_W (PRIO_W),
    .IPI_SRC(IPI_SRC)
  ) u_ipi (
    .en     (chk_req),
    .cur    (chk_cur),
    .ipi    (chk_ipi),
    .psrc   (psrc),
    .pprio  (pprio),
    .isipi  (isipi),
    .hit    (c_hit),
    .o_psrc (c_psrc),
    .o_pprio(c_pprio),
    .bnc_v  (c_bnc)
  );

  assign n_cur   = a_cur;
  assign n_ipi   = a_ipi;
  assign n_psrc  = c_hit ? c_psrc  : a_psrc;
  assign n_pprio = c_hit ? c_pprio : a_pprio;
  assign n_isipi = c_hit ? 1'b1    : a_isipi;
  assign bnc_v   = a_bnc | c_bnc;

endmodule

// File: rtl/irqp_deliver.sv
`timescale 1ns/1ps
// Judges one delivery request against the presenter state.
module irqp_deliver #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              dv,
  input  logic [SRC_W-1:0]  dsrc,
  input  logic [PRIO_W-1:0] dprio,
  input  logic [PRIO_W-1:0] cur,
  input  logic [SRC_W-1:0]  psrc,
  input  logic [PRIO_W-1:0] pprio,
  input  logic              isipi,
  output logic              take,
  output logic              refuse,
  output logic [SRC_W-1:0]  n_psrc,
  output logic [PRIO_W-1:0] n_pprio,
  output logic              n_isipi,
  output logic              bnc_v
);

  logic has_pend;
  logic loses;

  assign has_pend = (psrc != '0);
  assign loses    = (dprio >= cur) || (has_pend && (pprio <= dprio));
  assign take     = dv && !loses;
  assign refuse   = dv && loses;
  assign n_psrc   = take ? dsrc  : psrc;
  assign n_pprio  = take ? dprio : pprio;
  assign n_isipi  = take ? 1'b0  : isipi;
  assign bnc_v    = take && has_pend && !isipi;

endmodule

// File: rtl/irq_presenter.sv
`timescale 1ns/1ps
// Per-processor interrupt presenter: state registers and output stage.
module irq_presenter import irqp_pkg::*; #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dlv_valid,
  input  logic [SRC_W-1:0]        dlv_src,
  input  logic [PRIO_W-1:0]       dlv_prio,
  output logic                    dlv_taken,
  output logic                    dlv_refused,
  output logic                    bounce_valid,
  output logic [SRC_W-1:0]        bounce_src,
  input  logic                    reg_valid,
  input  logic [2:0]              reg_op,
  input  logic [SRC_W+PRIO_W-1:0] reg_wdata,
  output logic                    rd_valid,
  output logic [SRC_W+PRIO_W-1:0] rd_word,
  output logic [PRIO_W-1:0]       rd_ipi,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req,
  output logic                    int_out
);

  localparam int                WORD_W    = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  // architectural state
  logic [PRIO_W-1:0] cur_q, pprio_q, ipi_q;
  logic [SRC_W-1:0]  psrc_q;
  logic              isipi_q;

  // register-operation stage
  op_e               op_c;
  logic [PRIO_W-1:0] r_cur, r_pprio, r_ipi;
  logic [SRC_W-1:0]  r_psrc;
  logic              r_isipi;
  logic              rop_bnc, rop_resend, rop_eoi, rop_rd;

  assign op_c = op_e'(reg_op);

  irqp_regop #(
    .SRC_W  (SRC_W),
    .PRIO_W (PRIO_W),
    .IPI_SRC(IPI_SRC)
  ) u_regop (
    .op_v   (reg_valid),
    .op     (op_c),
    .wdata  (reg_wdata),
    .cur    (cur_q),
    .psrc   (psrc_q),
    .pprio  (pprio_q),
    .isipi  (isipi_q),
    .ipi    (ipi_q),
    .n_cur  (r_cur),
    .n_psrc (r_psrc),
    .n_pprio(r_pprio),
    .n_isipi(r_isipi),
    .n_ipi  (r_ipi),
    .bnc_v  (rop_bnc),
    .resend (rop_resend),
    .eoi_v  (rop_eoi),
    .rd_v   (rop_rd)
  );

  // delivery stage, judged on the state left by the register operation
  logic              d_take, d_refuse, dlv_bnc;
  logic [SRC_W-1:0]  d_psrc;
  logic [PRIO_W-1:0] d_pprio;
  logic              d_isipi;

  irqp_deliver #(
    .SRC_W (SRC_W),
    .PRIO_W(PRIO_W)
  ) u_deliver (
    .dv     (dlv_valid),
    .dsrc   (dlv_src),
    .dprio  (dlv_prio),
    .cur    (r_cur),
    .psrc   (r_psrc),
    .pprio  (r_pprio),
    .isipi  (r_isipi),
    .take   (d_take),
    .refuse (d_refuse),
    .n_psrc (d_psrc),
    .n_pprio(d_pprio),
    .n_isipi(d_isipi),
    .bnc_v  (dlv_bnc)
  );

  // bounce source: whichever stage evicted, it is the source that was
  // pending when that stage looked at the state
  logic              bnc_d;
  logic [SRC_W-1:0]  bnc_src_d;
  logic              state_en;

  always_comb begin
    bnc_d     = rop_bnc | dlv_bnc;
    bnc_src_d = rop_bnc ? psrc_q : r_psrc;
    state_en  = reg_valid | dlv_valid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cur_q   <= '0;
      psrc_q  <= '0;
      pprio_q <= PRIO_NONE;
      ipi_q   <= PRIO_NONE;
      isipi_q <= 1'b0;
    end else if (state_en) begin
      cur_q   <= r_cur;
      psrc_q  <= d_psrc;
      pprio_q <= d_pprio;
      ipi_q   <= r_ipi;
      isipi_q <= d_isipi;
    end
  end

  // output pulses
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dlv_taken    <= 1'b0;
      dlv_refused  <= 1'b0;
      bounce_valid <= 1'b0;
      rd_valid     <= 1'b0;
      eoi_valid    <= 1'b0;
      resend_req   <= 1'b0;
    end else begin
      dlv_taken    <= d_take;
      dlv_refused  <= d_refuse;
      bounce_valid <= bnc_d;
      rd_valid     <= rop_rd;
      eoi_valid    <= rop_eoi;
      resend_req   <= rop_resend;
    end
  end

  // output payloads, loaded only with their strobes
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bounce_src <= '0;
      rd_word    <= '0;
      rd_ipi     <= '0;
      eoi_src    <= '0;
    end else begin
      if (bnc_d) begin
        bounce_src <= bnc_src_d;
      end
      if (rop_rd) begin
        rd_word <= WORD_W'({cur_q, psrc_q});
        rd_ipi  <= ipi_q;
      end
      if (rop_eoi) begin
        eoi_src <= reg_wdata[SRC_W-1:0];
      end
    end
  end

  assign int_out = (psrc_q != '0);

endmodule

// File: rtl/irqp_checker.sv
`timescale 1ns/1ps
module irqp_checker #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dlv_valid,
  input logic [PRIO_W-1:0]       dlv_prio,
  input logic                    reg_valid,
  input logic [2:0]              reg_op,
  input logic [SRC_W+PRIO_W-1:0] reg_wdata,
  input logic                    dlv_taken,
  input logic                    dlv_refused,
  input logic                    int_out,
  input logic                    rd_valid,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    bounce_valid,
  input logic [SRC_W-1:0]        bounce_src,
  input logic [PRIO_W-1:0]       cur_q,
  input logic [SRC_W-1:0]        psrc_q,
  input logic [PRIO_W-1:0]       pprio_q,
  input logic [PRIO_W-1:0]       ipi_q,
  input logic                    rop_bnc,
  input logic                    dlv_bnc
);

  a_r2_low_prio_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !reg_valid && (dlv_prio >= cur_q)) |=> dlv_refused);

  a_r3_pending_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !reg_valid && (psrc_q != '0) && (pprio_q <= dlv_prio)) |=> dlv_refused);

  a_r4_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> (dlv_taken ^ dlv_refused));

  a_r4_taken_raises: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_taken |-> int_out);

  a_r6_accept_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && (reg_op == 3'd1) && !dlv_valid) |=> (!int_out && rd_valid));

  a_r9_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && (reg_op == 3'd5)) |=>
      (eoi_valid && (eoi_src == $past(reg_wdata[SRC_W-1:0]))
       && (cur_q == $past(reg_wdata[SRC_W +: PRIO_W]))));

  a_r10_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && (reg_op == 3'd2) && !dlv_valid) |=>
      ($stable(cur_q) && $stable(psrc_q) && $stable(pprio_q) && $stable(ipi_q)));

  a_r11_ipi_not_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    bounce_valid |-> (bounce_src != SRC_W'(IPI_SRC)));

  a_r11_single_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    !(rop_bnc && dlv_bnc));

endmodule

bind irq_presenter irqp_checker #(
  .SRC_W  (SRC_W),
  .PRIO_W (PRIO_W),
  .IPI_SRC(IPI_SRC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .dlv_valid   (dlv_valid),
  .dlv_prio    (dlv_prio),
  .reg_valid   (reg_valid),
  .reg_op      (reg_op),
  .reg_wdata   (reg_wdata),
  .dlv_taken   (dlv_taken),
  .dlv_refused (dlv_refused),
  .int_out     (int_out),
  .rd_valid    (rd_valid),
  .eoi_valid   (eoi_valid),
  .eoi_src     (eoi_src),
  .bounce_valid(bounce_valid),
  .bounce_src  (bounce_src),
  .cur_q       (cur_q),
  .psrc_q      (psrc_q),
  .pprio_q     (pprio_q),
  .ipi_q       (ipi_q),
  .rop_bnc     (rop_bnc),
  .dlv_bnc     (dlv_bnc)
);

// File: tb/test_irq_presenter.sv
`timescale 1ns/1ps
module test_irq_presenter;

  logic        clk;
  logic        rst_n;
  logic        dlv_valid;
  logic [23:0] dlv_src;
  logic [7:0]  dlv_prio;
  logic        dlv_taken, dlv_refused;
  logic        bounce_valid;
  logic [23:0] bounce_src;
  logic        reg_valid;
  logic [2:0]  reg_op;
  logic [31:0] reg_wdata;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend_req;
  logic        int_out;

  irq_presenter i_irq_presenter (
    .clk(clk), .rst_n(rst_n),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .dlv_taken(dlv_taken), .dlv_refused(dlv_refused),
    .bounce_valid(bounce_valid), .bounce_src(bounce_src),
    .reg_valid(reg_valid), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi(rd_ipi),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_req(resend_req), .int_out(int_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, written from the requirements
  logic [7:0]  m_cur, m_pprio, m_ipi;
  logic [23:0] m_psrc;
  bit          m_isipi;
  // expected outputs of one cycle
  bit          e_take, e_ref, e_bnc, e_eoi, e_res, e_rd;
  logic [23:0] e_bsrc, e_esrc;
  logic [31:0] e_word;
  logic [7:0]  e_ipi;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_ipi_check();
    if ((m_ipi < m_cur) && !((m_psrc != 0) && (m_pprio <= m_ipi))) begin
      if ((m_psrc != 0) && !m_isipi) begin
        e_bnc  = 1;
        e_bsrc = m_psrc;
      end
      m_psrc  = 24'd2;
      m_pprio = m_ipi;
      m_isipi = 1;
    end
  endtask

  task automatic model(input bit rv, input logic [2:0] op, input logic [31:0] wd,
                       input bit dv, input logic [23:0] ds, input logic [7:0] dp);
    logic [7:0] v;
    e_take = 0; e_ref = 0; e_bnc = 0; e_eoi = 0; e_res = 0; e_rd = 0;
    v = wd[7:0];
    if (rv) begin
      case (op)
        3'd1: begin
          e_rd = 1; e_word = {m_cur, m_psrc}; e_ipi = m_ipi;
          m_cur = m_pprio; m_psrc = 0; m_pprio = 8'hFF; m_isipi = 0;
        end
        3'd2: begin
          e_rd = 1; e_word = {m_cur, m_psrc}; e_ipi = m_ipi;
        end
        3'd3: begin
          if (v < m_cur) begin
            m_cur = v;
            if ((m_psrc != 0) && (v <= m_pprio)) begin
              if (!m_isipi) begin e_bnc = 1; e_bsrc = m_psrc; end
              m_psrc = 0; m_pprio = 8'hFF; m_isipi = 0;
            end
          end else begin
            m_cur = v;
            if (m_psrc == 0) begin e_res = 1; m_ipi_check(); end
          end
        end
        3'd4: begin
          m_ipi = v;
          m_ipi_check();
        end
        3'd5: begin
          m_cur = wd[31:24];
          e_eoi = 1; e_esrc = wd[23:0];
          if (m_psrc == 0) begin e_res = 1; m_ipi_check(); end
        end
        default: ;
      endcase
    end
    if (dv) begin
      if ((dp >= m_cur) || ((m_psrc != 0) && (m_pprio <= dp))) begin
        e_ref = 1;
      end else begin
        e_take = 1;
        if ((m_psrc != 0) && !m_isipi) begin e_bnc = 1; e_bsrc = m_psrc; end
        m_psrc = ds; m_pprio = dp; m_isipi = 0;
      end
    end
  endtask

  task automatic cycle(input string tag, input bit rv, input logic [2:0] op,
                       input logic [31:0] wd, input bit dv,
                       input logic [23:0] ds, input logic [7:0] dp);
    reg_valid = rv; reg_op = op; reg_wdata = wd;
    dlv_valid = dv; dlv_src = ds; dlv_prio = dp;
    model(rv, op, wd, dv, ds, dp);
    @(posedge clk);
    #2;
    reg_valid = 0; dlv_valid = 0;
    chk(tag, "int_out", 32'(int_out), 32'(m_psrc != 0));
    chk(tag, "dlv_taken", 32'(dlv_taken), 32'(e_take));
    chk(tag, "dlv_refused", 32'(dlv_refused), 32'(e_ref));
    chk(tag, "bounce_valid", 32'(bounce_valid), 32'(e_bnc));
    if (e_bnc) chk(tag, "bounce_src", 32'(bounce_src), 32'(e_bsrc));
    chk(tag, "eoi_valid", 32'(eoi_valid), 32'(e_eoi));
    if (e_eoi) chk(tag, "eoi_src", 32'(eoi_src), 32'(e_esrc));
    chk(tag, "resend_req", 32'(resend_req), 32'(e_res));
    chk(tag, "rd_valid", 32'(rd_valid), 32'(e_rd));
    if (e_rd) begin
      chk(tag, "rd_word", rd_word, e_word);
      chk(tag, "rd_ipi", 32'(rd_ipi), 32'(e_ipi));
    end
  endtask

  task automatic poll_expect(input string tag, input logic [31:0] w, input logic [7:0] ip);
    cycle(tag, 1, 3'd2, 0, 0, 0, 0);
    chk(tag, "poll word", rd_word, w);
    chk(tag, "poll ipi", 32'(rd_ipi), 32'(ip));
  endtask

  initial begin
    rst_n = 0; reg_valid = 0; reg_op = 0; reg_wdata = 0;
    dlv_valid = 0; dlv_src = 0; dlv_prio = 0;
    m_cur = 0; m_psrc = 0; m_pprio = 8'hFF; m_ipi = 8'hFF; m_isipi = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) cycle("R1", 0, 0, 0, 0, 0, 0);

    // R1: reset state observed through a poll
    poll_expect("R1", 32'h0000_0000, 8'hFF);
    chk("R1", "int_out low", 32'(int_out), 32'd0);
    // R2: current priority 0 refuses everything
    cycle("R2", 0, 0, 0, 1, 24'd5, 8'd3);
    chk("R2", "refused", 32'(dlv_refused), 32'd1);
    // R8: raise priority with nothing pending -> resend
    cycle("R8", 1, 3'd3, 32'hFF, 0, 0, 0);
    chk("R8", "resend", 32'(resend_req), 32'd1);
    // R4: take source 5 at priority 4
    cycle("R4", 0, 0, 0, 1, 24'd5, 8'd4);
    chk("R4", "line high", 32'(int_out), 32'd1);
    // R3: equal priority loses to the pending one
    cycle("R3", 0, 0, 0, 1, 24'd7, 8'd4);
    chk("R3", "refused", 32'(dlv_refused), 32'd1);
    // R4: better request evicts 5
    cycle("R4", 0, 0, 0, 1, 24'd7, 8'd2);
    chk("R4", "bounce 5", 32'(bounce_src), 32'd5);
    // R5: IPI priority 6 does not beat pending priority 2
    cycle("R5", 1, 3'd4, 32'h06, 0, 0, 0);
    poll_expect("R5", 32'hFF00_0007, 8'h06);
    // R5: IPI priority 1 evicts source 7
    cycle("R5", 1, 3'd4, 32'h01, 0, 0, 0);
    chk("R5", "bounce 7", 32'(bounce_src), 32'd7);
    poll_expect("R5", 32'hFF00_0002, 8'h01);
    // R11: evicting the IPI reports no bounce
    cycle("R11", 0, 0, 0, 1, 24'd9, 8'd0);
    chk("R11", "no bounce", 32'(bounce_valid), 32'd0);
    // R6: accept
    cycle("R6", 1, 3'd1, 0, 0, 0, 0);
    chk("R6", "accept word", rd_word, 32'hFF00_0009);
    chk("R6", "line low", 32'(int_out), 32'd0);
    poll_expect("R10", 32'h0000_0000, 8'h01);
    // R9: end-of-interrupt, resend re-raises the IPI
    cycle("R9", 1, 3'd5, 32'hFF00_0009, 0, 0, 0);
    chk("R9", "eoi src", 32'(eoi_src), 32'd9);
    poll_expect("R9", 32'hFF00_0002, 8'h01);
    // R7/R11: lowering priority drops the IPI without a bounce
    cycle("R7", 1, 3'd3, 32'h01, 0, 0, 0);
    chk("R11", "no ipi bounce", 32'(bounce_valid), 32'd0);
    chk("R7", "line low", 32'(int_out), 32'd0);
    cycle("R7", 0, 0, 0, 1, 24'd4, 8'd0);
    cycle("R7", 1, 3'd3, 32'h00, 0, 0, 0);
    chk("R7", "bounce 4", 32'(bounce_src), 32'd4);
    // R12: operation first (raise to 0x80, IPI re-raised), then delivery beats it
    cycle("R12", 1, 3'd3, 32'h80, 1, 24'd6, 8'd0);
    chk("R12", "taken", 32'(dlv_taken), 32'd1);
    poll_expect("R12", 32'h8000_0006, 8'h01);

    // constrained random traffic against the reference state
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit          rv, dv;
      logic [2:0]  op;
      logic [31:0] wd;
      logic [23:0] ds;
      logic [7:0]  dp;
      rv = ($urandom % 3) == 0;
      dv = ($urandom % 2) == 0;
      op = 3'(1 + ($urandom % 5));
      wd = {(($urandom % 8) == 0) ? 8'hFF : 8'($urandom % 16), 24'(1 + ($urandom % 15))};
      if (op != 3'd5) wd = (($urandom % 10) == 0) ? 32'hFF : 32'($urandom % 16);
      ds = 24'(1 + ($urandom % 14));
      if (ds >= 24'd2) ds = ds + 1;
      dp = 8'($urandom % 16);
      cycle("R12", rv, op, wd, dv, ds, dp);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule